// File: doc/BRIEF.md
# Boot Block Write-Protect Gate

This block sits between a flash command decoder and the program/erase engine and decides, for every program or erase request, whether it may proceed. It combines a per-block software protection vector with two hardware inputs. The first is a write-protect pin, given as a discrete level: low, high or high voltage. The second is a reset pin, given as two flags: driven low, or raised to the identification voltage. A granted request starts an operation timer that drives the busy output. A refused request is answered in one cycle and leaves the block idle.

The lowest two and highest two block indices are boot blocks. A low write-protect level locks them whatever the other inputs say. Once write-protect leaves the low level, they fall back on their own stored protection bits. Raising write-protect to high voltage from the idle state enters an unlock-bypass mode. Raising it while an operation is in flight raises an error flag instead. Holding the reset pin low for a minimum number of cycles forces a hardware reset of the sequencer. Busy then stays up until a recovery time has passed after the pin is released.

Top module: `wpg_gate`

## Requirements
- R1: After reset, grant, reject, busy, bypass_mode and hv_error are all 0.
- R2: A request to a block that is not locked gives a one-cycle grant pulse in the cycle after it is sampled. Busy then stays high for exactly OP_CYCLES cycles.
- R3: A request to a block whose protection bit is 1 gives a one-cycle reject pulse in the cycle after it is sampled, while rp_id is 0 and the block is not a boot block under write-protect low. Busy stays 0.
- R4: With wp_level = 2'b00 (low), requests to blocks 0, 1, NUM_BLOCKS-2 and NUM_BLOCKS-1 are rejected, whatever the protection bits and rp_id are.
- R5: With wp_level = 2'b01 (high) or 2'b10 (high voltage), each boot block is locked exactly when its own protection bit is 1.
- R6: While rp_id is 1, a set protection bit does not lock a block, except for a boot block under write-protect low.
- R7: A request sampled while busy is high is rejected and does not lengthen the busy period.
- R8: When wp_level changes to 2'b10 while busy is low, bypass_mode is 1 from the next cycle. It returns to 0 the cycle after wp_level leaves 2'b10.
- R9: When wp_level changes to 2'b10 while busy is high, hv_error is set and bypass_mode stays 0. hv_error clears the cycle after wp_level leaves 2'b10.
- R10: When rp_low is held for RESET_MIN consecutive cycles, busy is raised (aborting any operation). Busy stays high until RECOVER_CYCLES cycles after rp_low is released. A shorter low pulse has no effect.
- R11: Every sampled request gives exactly one of grant or reject in the next cycle. Neither is ever pulsed without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Program or erase request strobe |
| req_block | input | IDX_W | Block index of the request |
| prot_bits | input | NUM_BLOCKS | Stored per-block protection, 1 = protected |
| wp_level | input | 2 | Write-protect level: 00 low, 01 high, 10 high voltage, 11 treated as high |
| rp_low | input | 1 | Reset pin driven low |
| rp_id | input | 1 | Reset pin at identification voltage (temporary unprotect) |
| grant | output | 1 | Request accepted (one-cycle pulse) |
| reject | output | 1 | Request ignored (one-cycle pulse) |
| busy | output | 1 | Operation or reset recovery in progress |
| bypass_mode | output | 1 | Unlock-bypass mode active |
| hv_error | output | 1 | High voltage was applied outside the idle state |

## Verification
The assertions check on every cycle the handshake shape of R11, that no boot block is granted under write-protect low (R4), and that nothing is granted while busy (R7). They also check that bypass_mode and hv_error are exclusive and both follow the write-protect level (R8, R9), and that a grant is always followed by busy (R2). Only the bench scenarios can show the full lock decision across every combination of level, temporary unprotect and protection pattern (R3, R5, R6). The same holds for the exact busy durations and the length threshold of the hardware reset pulse (R2, R10).

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [1:0] {
    WP_LOW  = 2'b00,
    WP_HIGH = 2'b01,
    WP_HV   = 2'b10,
    WP_ALT  = 2'b11
  } wp_level_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OP   = 2'd1,
    ST_HOLD = 2'd2,
    ST_REC  = 2'd3
  } seq_state_e;

  function automatic logic is_boot(input int idx, input int nblk);
    return (idx < 2) || (idx >= nblk - 2);
  endfunction
endpackage

// File: rtl/wpg_lock_map.sv
module wpg_lock_map
  import wpg_pkg::*;
#(
  parameter int NUM_BLOCKS = 16
) (
  input  logic [NUM_BLOCKS-1:0] prot_bits,
  input  logic [1:0]            wp_level,
  input  logic                  rp_id,
  output logic [NUM_BLOCKS-1:0] lock_vec
);
  logic wp_is_low;
  assign wp_is_low = (wp_level == WP_LOW);

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    if (is_boot(b, NUM_BLOCKS)) begin : g_boot
      assign lock_vec[b] = wp_is_low | (prot_bits[b] & ~rp_id);
    end else begin : g_main
      assign lock_vec[b] = prot_bits[b] & ~rp_id;
    end
  end
endmodule

// File: rtl/wpg_mode_ctl.sv
module wpg_mode_ctl
  import wpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ok_n,
  input  logic [1:0] wp_level,
  input  logic       busy,
  output logic       bypass_mode,
  output logic       hv_error
);
  logic hv_now, hv_prev_q, bypass_q, bypass_d, err_q, err_d;

  assign hv_now = (wp_level == WP_HV);

  always_comb begin
    bypass_d = bypass_q;
    err_d    = err_q;
    if (!hv_now) begin
      bypass_d = 1'b0;
      err_d    = 1'b0;
    end else if (!hv_prev_q) begin
      if (busy) err_d    = 1'b1;
      else      bypass_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      hv_prev_q <= 1'b0;
      bypass_q  <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      hv_prev_q <= hv_now;
      bypass_q  <= bypass_d;
      err_q     <= err_d;
    end
  end

  assign bypass_mode = bypass_q;
  assign hv_error    = err_q;
endmodule

// File: rtl/wpg_seq.sv
module wpg_seq
  import wpg_pkg::*;
#(
  parameter int OP_CYCLES      = 4,
  parameter int RESET_MIN      = 4,
  parameter int RECOVER_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_ok_n,
  input  logic req_valid,
  input  logic req_allow,
  input  logic rp_low,
  output logic grant,
  output logic reject,
  output logic busy
);
  localparam int MAXC = (OP_CYCLES > RECOVER_CYCLES) ? OP_CYCLES : RECOVER_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int LW   = $clog2(RESET_MIN + 1);
  localparam logic [CW-1:0] OP_LOAD  = CW'(OP_CYCLES - 1);
  localparam logic [CW-1:0] REC_LOAD = CW'(RECOVER_CYCLES - 1);
  localparam logic [LW-1:0] LOW_LAST = LW'(RESET_MIN - 1);

  seq_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] low_q, low_d;
  logic grant_q, grant_d, reject_q, reject_d, hit;

  assign hit = rp_low && (low_q == LOW_LAST);

  always_comb begin
    if (!rp_low)              low_d = '0;
    else if (low_q != LOW_LAST) low_d = low_q + 1'b1;
    else                      low_d = low_q;
  end

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    grant_d  = 1'b0;
    reject_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (hit) begin
          st_d     = ST_HOLD;
          reject_d = req_valid;
        end else if (req_valid) begin
          if (req_allow) begin
            grant_d = 1'b1;
            st_d    = ST_OP;
            cnt_d   = OP_LOAD;
          end else begin
            reject_d = 1'b1;
          end
        end
      end
      ST_OP: begin
        reject_d = req_valid;
        if (hit)                st_d = ST_HOLD;
        else if (cnt_q == '0)   st_d = ST_IDLE;
        else                    cnt_d = cnt_q - 1'b1;
      end
      ST_HOLD: begin
        reject_d = req_valid;
        if (!rp_low) begin
          st_d  = ST_REC;
          cnt_d = REC_LOAD;
        end
      end
      default: begin
        reject_d = req_valid;
        if (hit)                st_d = ST_HOLD;
        else if (cnt_q == '0)   st_d = ST_IDLE;
        else                    cnt_d = cnt_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      low_q    <= '0;
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      low_q    <= low_d;
      grant_q  <= grant_d;
      reject_q <= reject_d;
    end
  end

  assign grant  = grant_q;
  assign reject = reject_q;
  assign busy   = (st_q != ST_IDLE);
endmodule

// File: rtl/wpg_gate.sv
module wpg_gate
  import wpg_pkg::*;
#(
  parameter int NUM_BLOCKS     = 16,
  parameter int OP_CYCLES      = 4,
  parameter int RESET_MIN      = 4,
  parameter int RECOVER_CYCLES = 6,
  localparam int IDX_W         = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [IDX_W-1:0]      req_block,
  input  logic [NUM_BLOCKS-1:0] prot_bits,
  input  logic [1:0]            wp_level,
  input  logic                  rp_low,
  input  logic                  rp_id,
  output logic                  grant,
  output logic                  reject,
  output logic                  busy,
  output logic                  bypass_mode,
  output logic                  hv_error
);
  logic [1:0] rst_sync_q;
  logic rst_ok_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok_n = rst_sync_q[1];

  logic [NUM_BLOCKS-1:0] lock_vec;
  logic in_range, req_allow;

  wpg_lock_map #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
    .prot_bits (prot_bits),
    .wp_level  (wp_level),
    .rp_id     (rp_id),
    .lock_vec  (lock_vec)
  );

  assign in_range  = (32'(req_block) < NUM_BLOCKS);
  assign req_allow = in_range && !lock_vec[req_block];

  wpg_seq #(
    .OP_CYCLES      (OP_CYCLES),
    .RESET_MIN      (RESET_MIN),
    .RECOVER_CYCLES (RECOVER_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_ok_n  (rst_ok_n),
    .req_valid (req_valid),
    .req_allow (req_allow),
    .rp_low    (rp_low),
    .grant     (grant),
    .reject    (reject),
    .busy      (busy)
  );

  wpg_mode_ctl u_mode (
    .clk         (clk),
    .rst_ok_n    (rst_ok_n),
    .wp_level    (wp_level),
    .busy        (busy),
    .bypass_mode (bypass_mode),
    .hv_error    (hv_error)
  );
endmodule

// File: rtl/wpg_gate_chk.sv
module wpg_gate_chk #(
  parameter int NUM_BLOCKS = 16,
  parameter int IDX_W      = 4
) (
  input logic             clk,
  input logic             rst_ok_n,
  input logic             req_valid,
  input logic [IDX_W-1:0] req_block,
  input logic [1:0]       wp_level,
  input logic             grant,
  input logic             reject,
  input logic             busy,
  input logic             bypass_mode,
  input logic             hv_error
);
  logic boot_req;
  assign boot_req = (32'(req_block) < 2) || (32'(req_block) >= NUM_BLOCKS - 2);

  // R11
  one_answer_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    req_valid |=> (grant ^ reject));
  // R11
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !req_valid |=> (!grant && !reject));
  // R4
  boot_locked_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (req_valid && wp_level == 2'b00 && boot_req) |=> !grant);
  // R7
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (req_valid && busy) |=> !grant);
  // R2
  grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    grant |-> busy);
  // R8
  bypass_drop_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (wp_level != 2'b10) |=> !bypass_mode);
  // R9
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !(bypass_mode && hv_error));
  // R9
  err_drop_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (wp_level != 2'b10) |=> !hv_error);
endmodule

bind wpg_gate wpg_gate_chk #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_ok_n    (rst_ok_n),
  .req_valid   (req_valid),
  .req_block   (req_block),
  .wp_level    (wp_level),
  .grant       (grant),
  .reject      (reject),
  .busy        (busy),
  .bypass_mode (bypass_mode),
  .hv_error    (hv_error)
);

// File: tb/wpg_gate_test.sv
`timescale 1ns/1ps
module wpg_gate_test;
  localparam int NB  = 16;
  localparam int OPC = 4;
  localparam int RMIN = 4;
  localparam int RREC = 6;
  localparam int IW  = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [IW-1:0] req_block;
  logic [NB-1:0] prot_bits;
  logic [1:0] wp_level;
  logic rp_low, rp_id;
  logic grant, reject, busy, bypass_mode, hv_error;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wpg_gate #(.NUM_BLOCKS(NB), .OP_CYCLES(OPC), .RESET_MIN(RMIN), .RECOVER_CYCLES(RREC)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_block(req_block),
    .prot_bits(prot_bits), .wp_level(wp_level), .rp_low(rp_low), .rp_id(rp_id),
    .grant(grant), .reject(reject), .busy(busy), .bypass_mode(bypass_mode),
    .hv_error(hv_error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      cycle();
    end
  endtask

  // issue one request, return grant/reject as sampled the next cycle
  task automatic send(input int b, output logic g, output logic r);
    req_valid = 1'b1;
    req_block = IW'(b);
    cycle();
    req_valid = 1'b0;
    g = grant;
    r = reject;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic g, r;
    int n;
    rst_n = 1'b0; req_valid = 1'b0; req_block = '0; prot_bits = '0;
    wp_level = 2'b01; rp_low = 1'b0; rp_id = 1'b0;
    repeat (3) cycle();
    rst_n = 1'b1;
    repeat (3) cycle();
    // R1
    chk({grant, reject, busy, bypass_mode, hv_error} == 5'b0, "R1",
        int'({grant, reject, busy, bypass_mode, hv_error}), 0);

    // Sweep: R2 R3 R4 R5 R6 R11
    for (int wp = 0; wp < 3; wp++) begin
      for (int id = 0; id < 2; id++) begin
        for (int p = 0; p < 2; p++) begin
          prot_bits = (p == 0) ? 16'hA5C3 : 16'h5A3C;
          wp_level = 2'(wp);
          rp_id = 1'(id);
          cycle();
          for (int b = 0; b < NB; b++) begin
            bit boot, lock;
            boot = (b < 2) || (b >= NB - 2);
            lock = (boot && wp == 0) || (prot_bits[b] && id == 0);
            send(b, g, r);
            if (lock) begin
              chk(r && !g, boot && wp == 0 ? "R4" : "R3", int'({g, r}), 1);
              chk(!busy, "R3", int'(busy), 0);
            end else begin
              chk(g && !r, (id == 1) ? "R6" : (boot ? "R5" : "R2"), int'({g, r}), 2);
              count_busy(n);
              chk(n == OPC, "R2", n, OPC);
            end
          end
        end
      end
    end

    // R7: request while busy is rejected, busy not extended
    wp_level = 2'b01; rp_id = 1'b0; prot_bits = '0;
    cycle();
    send(5, g, r);
    chk(g, "R7", int'(g), 1);
    send(6, g, r);
    chk(r && !g, "R7", int'({g, r}), 1);
    count_busy(n);
    chk(n == OPC - 1, "R7", n, OPC - 1);

    // R8: bypass entry from idle and exit
    cycle();
    wp_level = 2'b10;
    cycle();
    chk(bypass_mode && !hv_error, "R8", int'({bypass_mode, hv_error}), 2);
    repeat (3) cycle();
    chk(bypass_mode, "R8", int'(bypass_mode), 1);
    wp_level = 2'b00;
    cycle();
    chk(!bypass_mode, "R8", int'(bypass_mode), 0);

    // R9: high voltage while busy flags error
    wp_level = 2'b01;
    cycle();
    send(7, g, r);
    wp_level = 2'b10;
    cycle();
    chk(hv_error && !bypass_mode, "R9", int'({bypass_mode, hv_error}), 1);
    count_busy(n);
    chk(hv_error && !bypass_mode, "R9", int'({bypass_mode, hv_error}), 1);
    wp_level = 2'b01;
    cycle();
    chk(!hv_error, "R9", int'(hv_error), 0);

    // R10: short reset pulse has no effect
    cycle();
    rp_low = 1'b1;
    repeat (RMIN - 1) cycle();
    rp_low = 1'b0;
    chk(!busy, "R10", int'(busy), 0);
    cycle();
    send(8, g, r);
    chk(g, "R10", int'(g), 1);
    count_busy(n);
    // R10: long pulse aborts an operation and holds busy through recovery
    send(9, g, r);
    rp_low = 1'b1;
    repeat (RMIN) cycle();
    chk(busy, "R10", int'(busy), 1);
    repeat (OPC + 2) cycle();
    chk(busy, "R10", int'(busy), 1);
    rp_low = 1'b0;
    cycle();
    count_busy(n);
    chk(n == RREC, "R10", n, RREC);
    send(10, g, r);
    chk(g, "R10", int'(g), 1);
    count_busy(n);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule